// File: doc/BRIEF.md
# Dual-Mode Speculative Decision Selector

This block is the digital back end of a loop-unrolled decision-feedback equalizer. A bank of eight comparators per unit interval slices the received sample against fixed speculative thresholds. Each cycle the block receives those comparator bits for `NSLICE` interleaved unit intervals and picks, for each one, the comparator outputs that match the symbols already decided. It returns the resolved symbols one clock later.

In four-level mode the channel is shaped so that the first post-cursor is half the main cursor. The three thresholds needed for every possible previous symbol therefore fall on a shared grid of eight levels at k - 3.5 main-cursor units (k = 0..7). In two-level mode the same eight comparators each hold one hypothesis of the previous three bits, which cancels three post-cursor taps. For every interval the selected comparator bits are also forwarded for use by a baud-rate phase detector.

Decisions chain from slice to slice inside a cycle. The last slice's decision is registered and seeds slice 0 of the next cycle. The operating mode is captured only while the synchronous reset is held.

Top module: `spec_dfe_selector`

## Requirements
- R1: While `rst_i` is high, `sym_o` and `pd_o` read zero. The decision history is cleared to level 0 (symbol -3) in four-level mode and to bits 000 (all -1) in two-level mode.
- R2: `mode_i` (0 = four-level, 1 = two-level) is captured only in cycles where `rst_i` is high. Changes outside reset have no effect on decoding.
- R3: Four-level mode: with previous level p (0..3 meaning -3, -1, +1, +3), the slice uses comparators p, p+2 and p+4 of its 8-bit group. Comparator k has threshold k - 3.5 and reads 1 when the sample is above it.
- R4: Four-level mode: the number of selected comparators that read 1 gives level 0..3. The level is output as Gray code 00, 01, 11, 10, and slice s drives `sym_o[2s+1:2s]`.
- R5: Two-level mode: the decided bit is comparator number {b3,b2,b1}, where b1 (bit 0 of the index) is the most recent bit and 1 means +1. Slice s outputs {0, bit} on `sym_o[2s+1:2s]`.
- R6: Slice 0 holds the earliest interval of a cycle. Slice s takes slice s-1 as its history, and slice 0 takes the last slice of the previous cycle, including the three-bit history in two-level mode.
- R7: Comparator bits applied in one cycle produce their symbols on `sym_o` and `pd_o` after exactly one rising clock edge.
- R8: `pd_o[3s+2:3s]` carries, for slice s, the selected comparators {c[p+4], c[p+2], c[p]} in four-level mode, and {0, 0, selected bit} in two-level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; mode is captured while high |
| mode_i | input | 1 | 0 = four-level 1-tap, 1 = two-level 3-tap |
| cmp_i | input | 8*NSLICE | Comparator bits, 8 per slice, bit k = threshold k |
| sym_o | output | 2*NSLICE | Decided symbols, 2 bits per slice |
| pd_o | output | 3*NSLICE | Selected comparator bits for phase detection, 3 per slice |

## Verification
The bench builds the block with `NSLICE = 4`. The last slice therefore feeds slice 0 on every edge, and the three-bit two-level history always spans a cycle boundary for the first three slices. An ideal channel model turns random and de Bruijn symbol streams into comparator bits, so every previous/current symbol pair and every three-bit history is decoded. Switching mode through reset, and toggling `mode_i` without it, are both exercised.

// File: rtl/spec_dfe_pkg.sv
package spec_dfe_pkg;
  localparam int NCMP = 8;
  localparam int SYM_W = 2;
  localparam int PD_W = 3;
  localparam int HIST_W = 3;

  typedef enum logic {MODE_PAM4 = 1'b0, MODE_NRZ = 1'b1} dfe_mode_e;

  // level 0..3 to Gray code
  function automatic logic [1:0] lvl_to_gray(input logic [1:0] lvl);
    return {lvl[1], lvl[1] ^ lvl[0]};
  endfunction

  // thermometer (bit 0 lowest) to level; highest set bit wins
  function automatic logic [1:0] therm_to_lvl(input logic [2:0] t);
    if (t[2]) return 2'd3;
    if (t[1]) return 2'd2;
    if (t[0]) return 2'd1;
    return 2'd0;
  endfunction
endpackage

// File: rtl/spec_dfe_pam4_pick.sv
module spec_dfe_pam4_pick
  import spec_dfe_pkg::*;
(
  input  logic [NCMP-1:0] cmp_i,
  input  logic [1:0]      prev_lvl_i,
  output logic [PD_W-1:0] therm_o,
  output logic [1:0]      lvl_o
);
  localparam int IDX_W = $clog2(NCMP);
  localparam int STEP  = 2;

  for (genvar j = 0; j < PD_W; j++) begin : g_tap
    logic [IDX_W-1:0] idx;
    assign idx        = IDX_W'(prev_lvl_i) + IDX_W'(STEP * j);
    assign therm_o[j] = cmp_i[idx];
  end

  assign lvl_o = therm_to_lvl(therm_o);
endmodule

// File: rtl/spec_dfe_nrz_pick.sv
module spec_dfe_nrz_pick
  import spec_dfe_pkg::*;
(
  input  logic [NCMP-1:0]   cmp_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic              bit_o
);
  assign bit_o = cmp_i[hist_i];
endmodule

// File: rtl/spec_dfe_slice.sv
module spec_dfe_slice
  import spec_dfe_pkg::*;
(
  input  dfe_mode_e          mode_i,
  input  logic [NCMP-1:0]    cmp_i,
  input  logic [HIST_W-1:0]  hist_i,
  output logic [HIST_W-1:0]  hist_o,
  output logic [SYM_W-1:0]   sym_o,
  output logic [PD_W-1:0]    pd_o
);
  logic [PD_W-1:0] pam_therm;
  logic [1:0]      pam_lvl;
  logic            nrz_bit;

  spec_dfe_pam4_pick u_pam (
    .cmp_i      (cmp_i),
    .prev_lvl_i (hist_i[1:0]),
    .therm_o    (pam_therm),
    .lvl_o      (pam_lvl)
  );

  spec_dfe_nrz_pick u_nrz (
    .cmp_i  (cmp_i),
    .hist_i (hist_i),
    .bit_o  (nrz_bit)
  );

  always_comb begin
    if (mode_i == MODE_NRZ) begin
      hist_o = {hist_i[HIST_W-2:0], nrz_bit};
      sym_o  = {1'b0, nrz_bit};
      pd_o   = {{(PD_W-1){1'b0}}, nrz_bit};
    end else begin
      hist_o = {1'b0, pam_lvl};
      sym_o  = lvl_to_gray(pam_lvl);
      pd_o   = pam_therm;
    end
  end
endmodule

// File: rtl/spec_dfe_selector.sv
module spec_dfe_selector
  import spec_dfe_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   mode_i,
  input  logic [NSLICE*8-1:0]    cmp_i,
  output logic [NSLICE*2-1:0]    sym_o,
  output logic [NSLICE*3-1:0]    pd_o
);
  localparam int CMP_BUS = NSLICE * NCMP;
  localparam int SYM_BUS = NSLICE * SYM_W;
  localparam int PD_BUS  = NSLICE * PD_W;

  dfe_mode_e          mode_q;
  logic [HIST_W-1:0]  hist_q;
  logic [HIST_W-1:0]  chain [NSLICE+1];
  logic [SYM_BUS-1:0] sym_d, sym_q;
  logic [PD_BUS-1:0]  pd_d, pd_q;
  logic [CMP_BUS-1:0] cmp_w;

  assign cmp_w    = cmp_i;
  assign chain[0] = hist_q;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    spec_dfe_slice u_slice (
      .mode_i (mode_q),
      .cmp_i  (cmp_w[g*NCMP +: NCMP]),
      .hist_i (chain[g]),
      .hist_o (chain[g+1]),
      .sym_o  (sym_d[g*SYM_W +: SYM_W]),
      .pd_o   (pd_d[g*PD_W +: PD_W])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= dfe_mode_e'(mode_i);
      hist_q <= '0;
      sym_q  <= '0;
      pd_q   <= '0;
    end else begin
      hist_q <= chain[NSLICE];
      sym_q  <= sym_d;
      pd_q   <= pd_d;
    end
  end

  assign sym_o = sym_q;
  assign pd_o  = pd_q;
endmodule

// File: rtl/spec_dfe_selector_chk.sv
module spec_dfe_selector_chk #(
  parameter int NSLICE = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                mode_q,
  input logic [2:0]          hist_q,
  input logic [NSLICE*2-1:0] sym_o,
  input logic [NSLICE*3-1:0] pd_o
);
  localparam int LAST = NSLICE - 1;

  logic rst_d;
  always_ff @(posedge clk_i) rst_d <= rst_i;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rst_d |-> (sym_o == '0 && pd_o == '0 && hist_q == '0));

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_d |-> $stable(mode_q));

  // R6
  hist_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_d && !mode_q) |->
      hist_q[1:0] == {sym_o[2*LAST+1], sym_o[2*LAST+1] ^ sym_o[2*LAST]});

  // R6
  nrz_hist_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_d && mode_q) |-> hist_q[0] == sym_o[2*LAST]);

  for (genvar s = 0; s < NSLICE; s++) begin : g_lane
    logic [2:0] pdf;
    logic [1:0] ones;
    assign pdf  = pd_o[3*s +: 3];
    assign ones = 2'($countones(pdf));

    // R4
    pam4_gray_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mode_q && (pdf == 3'b000 || pdf == 3'b001 || pdf == 3'b011 || pdf == 3'b111))
        |-> sym_o[2*s +: 2] == {ones[1], ones[1] ^ ones[0]});

    // R5
    nrz_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      mode_q |-> (sym_o[2*s+1] == 1'b0 && pdf[2:1] == 2'b00 && pdf[0] == sym_o[2*s]));
  end
endmodule

bind spec_dfe_selector spec_dfe_selector_chk #(.NSLICE(NSLICE)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .mode_q (mode_q),
  .hist_q (hist_q),
  .sym_o  (sym_o),
  .pd_o   (pd_o)
);

// File: tb/spec_dfe_selector_tb.sv
module spec_dfe_selector_tb;
  localparam int NS = 4;
  localparam int CLK_NS = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode = 1'b0;
  logic [NS*8-1:0] cmp = '0;
  logic [NS*2-1:0] sym;
  logic [NS*3-1:0] pd;

  int checks = 0;
  int errors = 0;
  int pam_prev = 0;
  logic [2:0] nrz_h = 3'b000;

  always #(CLK_NS/2) clk = ~clk;

  spec_dfe_selector #(.NSLICE(NS)) u_dut (
    .clk_i (clk), .rst_i (rst), .mode_i (mode),
    .cmp_i (cmp), .sym_o (sym), .pd_o (pd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] gray_of(input int lv);
    case (lv)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2:0] therm_of(input int lv);
    case (lv)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int isi3(input logic [2:0] h);
    return 4 * (h[0] ? 1 : -1) + 2 * (h[1] ? 1 : -1) + (h[2] ? 1 : -1);
  endfunction

  // one cycle of four-level symbols; checks R3 R4 R6 R7 R8
  task automatic pam4_step(input logic [2*NS-1:0] lv, input string tag);
    logic [NS*2-1:0] es;
    logic [NS*3-1:0] ep;
    for (int s = 0; s < NS; s++) begin
      int a = int'(lv[2*s +: 2]);
      int y2 = 2 * (2 * a - 3) + (2 * pam_prev - 3);
      for (int k = 0; k < 8; k++) cmp[s*8 + k] = (y2 > 2 * k - 7);
      es[2*s +: 2] = gray_of(a);
      ep[3*s +: 3] = therm_of(a);
      pam_prev = a;
    end
    @(negedge clk);
    check({tag, " R3 R4 R6 R7 sym"}, 32'(sym), 32'(es));
    check({tag, " R8 pd"}, 32'(pd), 32'(ep));
  endtask

  // one cycle of two-level bits; checks R5 R6 R7 R8
  task automatic nrz_step(input logic [NS-1:0] bits, input string tag);
    logic [NS*2-1:0] es;
    logic [NS*3-1:0] ep;
    for (int s = 0; s < NS; s++) begin
      int y8 = 8 * (bits[s] ? 1 : -1) + isi3(nrz_h);
      for (int k = 0; k < 8; k++) cmp[s*8 + k] = (y8 > isi3(3'(k)));
      es[2*s +: 2] = {1'b0, bits[s]};
      ep[3*s +: 3] = {2'b00, bits[s]};
      nrz_h = {nrz_h[1:0], bits[s]};
    end
    @(negedge clk);
    check({tag, " R5 R6 R7 sym"}, 32'(sym), 32'(es));
    check({tag, " R8 pd"}, 32'(pd), 32'(ep));
  endtask

  task automatic t_reset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    mode = m;
    for (int i = 0; i < 3; i++) begin
      cmp = $urandom();
      @(negedge clk);
      check("R1 sym in reset", 32'(sym), 0);
      check("R1 pd in reset", 32'(pd), 0);
    end
    rst = 1'b0;
    pam_prev = 0;
    nrz_h = 3'b000;
  endtask

  task automatic t_pam4_debruijn();
    int seq[16] = '{0,0,1,0,2,0,3,1,1,2,1,3,2,2,3,3};
    for (int c = 0; c < 4; c++) begin
      logic [2*NS-1:0] lv;
      for (int s = 0; s < NS; s++) lv[2*s +: 2] = 2'(seq[c*NS + s]);
      pam4_step(lv, "pam4 pairs");
    end
  endtask

  task automatic t_pam4_random(input int n);
    for (int i = 0; i < n; i++) pam4_step((2*NS)'($urandom()), "pam4 random");
  endtask

  task automatic t_nrz_debruijn();
    logic [7:0] seq = 8'b11101000;
    for (int c = 0; c < 8 / NS; c++) nrz_step(NS'(seq >> (c*NS)), "nrz histories");
    nrz_step('1, "nrz ones");
    nrz_step('0, "nrz zeros");
  endtask

  task automatic t_nrz_random(input int n);
    for (int i = 0; i < n; i++) nrz_step(NS'($urandom()), "nrz random");
  endtask

  task automatic t_mode_ignore(input logic cur);
    for (int i = 0; i < 40; i++) begin
      mode = ~mode;
      if (cur) nrz_step(NS'($urandom()), "R2 mode toggle");
      else pam4_step((2*NS)'($urandom()), "R2 mode toggle");
    end
  endtask

  initial begin
    #(CLK_NS * 60000);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset(1'b0);
    t_pam4_debruijn();
    t_pam4_random(300);
    t_mode_ignore(1'b0);
    t_reset(1'b1);
    t_nrz_debruijn();
    t_nrz_random(300);
    t_mode_ignore(1'b1);
    t_reset(1'b0);
    t_pam4_step_after_reset();
    t_pam4_random(50);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R1: first decision after reset resolves against level 0 history
  task automatic t_pam4_step_after_reset();
    pam4_step({(2*NS){1'b1}}, "R1 history after reset");
  endtask
endmodule